// File: doc/BRIEF.md
# Burst Address Sequencer

This block turns one captured start address into the address sequence of a four-beat memory burst. On a rising clock edge where the device is selected and either of two start strobes is high (one driven by a processor, one by a cache controller), the block takes the whole input address and presents it on its output. On later edges, each cycle with the advance input high moves the low two address bits to the next beat. Each cycle without it leaves the address where it is, so a burst can be suspended and resumed.

The order of the beats depends on a mode input that is taken at the start of each burst. In linear order the low two bits count upward from the start offset and wrap modulo four. In interleaved order they equal the start offset XOR a beat count that runs 0, 1, 2, 3. The upper address bits never change within a burst. The block contains no storage array and no data path. It only produces the address that such an array would be read or written with.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted and after it is released, mem_addr reads 0 until the first load.
- R2: The device is selected when cs_a=1, cs_b=1 and cs_n_c=0. A selected edge with strobe_proc=1 or strobe_ctrl=1 is a load. After that edge mem_addr equals the sampled addr_in and the beat count restarts at 0.
- R3: A strobe on an edge where any enable deselects the device is ignored. With advance low the address is unchanged. With advance high the edge acts as a plain advance.
- R4: Bits ADDR_W-1:2 of mem_addr stay equal to the loaded value across every advance of a burst.
- R5: With order mode 0 (linear), after k advances the low two bits equal (start + k) mod 4.
- R6: With order mode 1 (interleaved), after k advances the low two bits equal start XOR (k mod 4).
- R7: The order mode is sampled from mode_interleave only on a load edge. Changing mode_interleave within a burst has no effect on the sequence.
- R8: An edge with advance=0 and no load leaves mem_addr unchanged (suspend).
- R9: If a load and advance=1 occur on the same edge, the load wins: mem_addr becomes addr_in at beat 0.
- R10: The beat count wraps modulo 4, so the fourth advance returns the low bits to the start offset and a fifth gives the first-advance value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | Start address for a new burst |
| strobe_proc | input | 1 | Processor-side burst start strobe |
| strobe_ctrl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| mode_interleave | input | 1 | Order for the next burst: 0 linear, 1 interleaved |
| cs_a | input | 1 | Chip enable, active high |
| cs_b | input | 1 | Chip enable, active high |
| cs_n_c | input | 1 | Chip enable, active low |
| mem_addr | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with ADDR_W=12, which leaves a 10-bit upper field. A non-zero upper pattern there shows at once any carry leaking out of the beat bits. At this width every start offset in both orders can be checked against a written-out ordering table, including the wrap on the fourth and fifth advances. The same width also covers each enable deselecting on its own, a strobe and advance together, and a mode change in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_BITS = 2;

  typedef logic [BEAT_BITS-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Low address bits of a beat, given start offset and beat count.
  function automatic beat_t beat_offset(beat_t start, beat_t cnt, order_e ord);
    beat_t res;
    if (ord == ORD_XOR) res = start ^ cnt;
    else                res = beat_t'(start + cnt);
    return res;
  endfunction
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic strobe_proc,
  input  logic strobe_ctrl,
  input  logic advance,
  input  logic cs_a,
  input  logic cs_b,
  input  logic cs_n_c,
  output logic dev_sel,
  output logic load_evt,
  output logic step_evt
);
  logic any_strobe;

  always_comb begin
    dev_sel    = cs_a & cs_b & ~cs_n_c;
    any_strobe = strobe_proc | strobe_ctrl;
    load_evt   = dev_sel & any_strobe;
    // a load takes precedence over advance
    step_evt   = advance & ~load_evt;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_evt,
  input  logic  step_evt,
  output beat_t cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load_evt) cnt <= '0;
    else if (step_evt) cnt <= beat_t'(cnt + 1'b1);
  end

  a_r9_load_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt == '0);

  a_r10_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load_evt && cnt == beat_t'(3)) |=> cnt == '0);

  a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !load_evt) |=> $stable(cnt));
endmodule

// File: rtl/burst_addr_regs.sv
module burst_addr_regs
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_evt,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic                        mode_in,
  output logic [ADDR_W-BEAT_BITS-1:0] upper_q,
  output beat_t                       start_q,
  output order_e                      order_q
);
  localparam int UP_W = ADDR_W - BEAT_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      order_q <= ORD_LINEAR;
    end else if (load_evt) begin
      upper_q <= addr_in[ADDR_W-1:BEAT_BITS];
      start_q <= addr_in[BEAT_BITS-1:0];
      order_q <= order_e'(mode_in);
    end
  end

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(upper_q));

  a_r7_order_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(order_q));

  initial begin
    a_r4_width_ok: assert (UP_W > 0);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_proc,
  input  logic              strobe_ctrl,
  input  logic              advance,
  input  logic              mode_interleave,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              cs_n_c,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int UP_W = ADDR_W - BEAT_BITS;

  logic            dev_sel;
  logic            load_evt;
  logic            step_evt;
  beat_t           cnt;
  logic [UP_W-1:0] upper_q;
  beat_t           start_q;
  order_e          order_q;

  burst_load_ctrl u_ctrl (
    .strobe_proc (strobe_proc),
    .strobe_ctrl (strobe_ctrl),
    .advance     (advance),
    .cs_a        (cs_a),
    .cs_b        (cs_b),
    .cs_n_c      (cs_n_c),
    .dev_sel     (dev_sel),
    .load_evt    (load_evt),
    .step_evt    (step_evt)
  );

  burst_beat_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .cnt      (cnt)
  );

  burst_addr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .addr_in  (addr_in),
    .mode_in  (mode_interleave),
    .upper_q  (upper_q),
    .start_q  (start_q),
    .order_q  (order_q)
  );

  always_comb mem_addr = {upper_q, beat_offset(start_q, cnt, order_q)};

  // R2: a selected strobe presents the sampled address
  a_r2_load_address: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel && (strobe_proc || strobe_ctrl)) |=> mem_addr == $past(addr_in));

  a_r3_deselect_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_sel && !advance) |=> $stable(mem_addr));

  a_r8_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !advance) |=> $stable(mem_addr));

  a_r4_upper_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && advance) |=> mem_addr[ADDR_W-1:BEAT_BITS] == $past(mem_addr[ADDR_W-1:BEAT_BITS]));
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_proc = 1'b0, strobe_ctrl = 1'b0, advance = 1'b0;
  logic          mode_interleave = 1'b0;
  logic          cs_a = 1'b1, cs_b = 1'b1, cs_n_c = 1'b0;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl), .advance(advance),
    .mode_interleave(mode_interleave),
    .cs_a(cs_a), .cs_b(cs_b), .cs_n_c(cs_n_c), .mem_addr(mem_addr)
  );

  // Ordering table for the interleaved mode, linear by modular add.
  function automatic logic [1:0] ref_low(logic [1:0] s, int k, bit il);
    logic [1:0] r;
    int kk;
    kk = k % 4;
    if (!il) r = 2'((int'(s) + kk) % 4);
    else begin
      case ({s, 2'(kk)})
        4'b0000: r = 2'd0; 4'b0001: r = 2'd1; 4'b0010: r = 2'd2; 4'b0011: r = 2'd3;
        4'b0100: r = 2'd1; 4'b0101: r = 2'd0; 4'b0110: r = 2'd3; 4'b0111: r = 2'd2;
        4'b1000: r = 2'd2; 4'b1001: r = 2'd3; 4'b1010: r = 2'd0; 4'b1011: r = 2'd1;
        4'b1100: r = 2'd3; 4'b1101: r = 2'd2; 4'b1110: r = 2'd1; default: r = 2'd0;
      endcase
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, sample 1 ns after the next rising edge.
  task automatic cyc(logic [AW-1:0] a, bit sp, bit sc, bit adv, logic [2:0] sel);
    @(negedge clk);
    addr_in = a; strobe_proc = sp; strobe_ctrl = sc; advance = adv;
    {cs_a, cs_b, cs_n_c} = sel;
    @(posedge clk);
    #1;
  endtask

  localparam logic [2:0] SEL = 3'b110;

  task automatic t_reset();
    check(mem_addr == '0, "R1 during reset", mem_addr, '0);
    @(negedge clk); rst_n = 1'b1;
    cyc('0, 0, 0, 0, SEL);
    check(mem_addr == '0, "R1 after release", mem_addr, '0);
  endtask

  task automatic t_order(bit il);
    logic [9:0] up;
    logic [AW-1:0] base, exp;
    for (int s = 0; s < 4; s++) begin
      up = 10'h2A5 ^ 10'(s * 37);
      base = {up, 2'(s)};
      mode_interleave = il;
      cyc(base, s[0] == 0, s[0] == 1, 0, SEL);
      check(mem_addr == base, "R2 load start", mem_addr, base);
      for (int k = 1; k <= 5; k++) begin
        cyc(12'hFFF, 0, 0, 1, SEL);
        exp = {up, ref_low(2'(s), k, il)};
        if (il) check(mem_addr == exp, "R6 interleaved beat", mem_addr, exp);
        else    check(mem_addr == exp, "R5 linear beat", mem_addr, exp);
        check(mem_addr[AW-1:2] == up, "R4 upper fixed", mem_addr, exp);
        if (k == 4) check(mem_addr == base, "R10 wrap to start", mem_addr, base);
      end
    end
  endtask

  task automatic t_suspend();
    logic [AW-1:0] exp;
    mode_interleave = 1'b0;
    cyc(12'h5C2, 1, 0, 0, SEL);
    cyc('0, 0, 0, 1, SEL);
    exp = 12'h5C3;
    for (int i = 0; i < 3; i++) begin
      cyc(12'hABC, 0, 0, 0, SEL);
      check(mem_addr == exp, "R8 suspend holds", mem_addr, exp);
    end
    cyc('0, 0, 0, 1, SEL);
    check(mem_addr == 12'h5C0, "R8 resume after suspend", mem_addr, 12'h5C0);
  endtask

  task automatic t_priority();
    mode_interleave = 1'b1;
    cyc(12'h101, 1, 0, 0, SEL);
    cyc('0, 0, 0, 1, SEL);
    cyc(12'h7F6, 0, 1, 1, SEL);
    check(mem_addr == 12'h7F6, "R9 strobe beats advance", mem_addr, 12'h7F6);
    cyc('0, 0, 0, 1, SEL);
    check(mem_addr == 12'h7F7, "R9 burst restarted at beat 0", mem_addr, 12'h7F7);
  endtask

  task automatic t_deselect();
    logic [2:0] bad [3] = '{3'b010, 3'b100, 3'b111};
    mode_interleave = 1'b0;
    cyc(12'h3A1, 1, 0, 0, SEL);
    for (int i = 0; i < 3; i++) begin
      cyc(12'h0F0, 1, 1, 0, bad[i]);
      check(mem_addr == 12'h3A1, "R3 deselected strobe ignored", mem_addr, 12'h3A1);
    end
    cyc(12'h0F0, 1, 0, 1, 3'b000);
    check(mem_addr == 12'h3A2, "R3 deselected strobe with advance steps", mem_addr, 12'h3A2);
  endtask

  task automatic t_mode_latch();
    mode_interleave = 1'b0;
    cyc(12'h445, 1, 0, 0, SEL);
    mode_interleave = 1'b1;
    cyc('0, 0, 0, 1, SEL);
    check(mem_addr == 12'h446, "R7 mode change mid-burst ignored", mem_addr, 12'h446);
    cyc('0, 0, 0, 1, SEL);
    check(mem_addr == 12'h447, "R7 linear order kept", mem_addr, 12'h447);
    cyc(12'h445, 0, 1, 0, SEL);
    cyc('0, 0, 0, 1, SEL);
    check(mem_addr == 12'h444, "R7 new mode taken at next load", mem_addr, 12'h444);
  endtask

  initial begin
    #1;
    t_reset();
    t_order(1'b0);
    t_order(1'b1);
    t_suspend();
    t_priority();
    t_deselect();
    t_mode_latch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule